// File: doc/BRIEF.md
# Coprocessor Hazard Spacer

This block sits in front of a coprocessor's instruction issue and sees the 32-bit instruction words of a single in-order stream. It picks out the words aimed at the coprocessor and tracks a short history of the words it has already emitted. When the next input word would form one of several known data-corrupting sequences with that history, the block emits a fixed NOP word instead and holds the input. It repeats this until the sequence is safe, then lets the held word through. Apart from the inserted NOPs, words leave in the order they arrived.

Both sides use valid/ready. An input word is accepted on a rising edge where `in_valid` and `in_ready` are both high. An output word is taken on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word stays unchanged. Back-pressure reaches the input in the same cycle, because `in_ready` is low whenever the output register is full and not being drained.

`in_taken` is sampled along with each input word and marks that word as a taken branch. Hazard rules count only the words actually emitted, NOPs included. Idle cycles do not count as separation.

Top module: `copro_hazard_spacer`

## Requirements
- R1: After reset, `out_valid` is 0, and `in_ready` is 1 while the output is empty.
- R2: An accepted word appears on `out_word` with `out_valid` high in the cycle after acceptance. The output word holds while `out_valid` is high and `out_ready` is low, and words leave in arrival order.
- R3: A word counts as a coprocessor word only when bits 11:8 hold 4, 5 or 6. In a coprocessor word, bits 31:28 are the condition (0xE means always), bits 15:12 are the register, a load/store has bits 27:25 = 110 with bit 20 = 1 for a load and bit 22 = 1 for two-word, and a data op has bits 27:24 = 1110 with bit 4 = 0. Words with any other number in bits 11:8 never cause an insertion.
- R4: The two emitted slots after a word accepted with `in_taken` high never hold a coprocessor word. NOPs fill them instead.
- R5: With `WIDE_TAIL` = 1 (the default), any coprocessor word directly after an emitted two-word coprocessor load/store gets one NOP ahead of it. A non-coprocessor follower passes without a NOP.
- R6: A conditional two-word coprocessor load/store directly followed by a coprocessor load/store with a different condition gets one NOP between them.
- R7: With `WIDE_TAIL` = 0, no NOP is inserted after a two-word coprocessor load/store that is unconditional or whose follower has the same condition, or when the follower is not a load/store.
- R8: A conditional coprocessor data op or load whose register was written by a coprocessor data op in one of the two previous emitted slots is delayed by NOPs until two words separate them.
- R9: A coprocessor store whose register was the target of such a shadowed conditional write within the last three emitted slots is delayed by NOPs until three words separate them.
- R10: Idle cycles between input words do not count as separation. Only emitted words, including NOPs, do.
- R11: The inserted word is the constant `NOP_WORD` (default 0xE1A00000), and the held input word is emitted right after the last NOP it needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle if valid |
| in_word | input | 32 | Input instruction word |
| in_taken | input | 1 | Input word is a taken branch |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | 32 | Emitted instruction word or NOP |

## Verification
An accepted word is due on the output one clock after the edge that accepted it. Each inserted NOP takes the output register on the edge where the input was refused, so a word that needs N NOPs appears N cycles later than it otherwise would. The bench drives on the falling edge and samples one nanosecond later, so every comparison sees values that are stable until the next rising edge. It checks each word the driver sends in the cycle after its acceptance, and a scoreboard checks every emitted word against a queue of expected words, NOPs included, in order. Back-pressure phases show that the output holds its value, and idle gaps placed between the words of a hazard show that the inserted NOPs stay the same.

// File: rtl/copro_hazard_spacer_pkg.sv
`timescale 1ns/1ps
package copro_hazard_spacer_pkg;
  localparam int WORD_W = 32;
  localparam logic [3:0] COND_ALWAYS = 4'hE;

  // decoded view of one word
  typedef struct packed {
    logic       cp;      // aimed at the coprocessor
    logic       ls;      // coprocessor load or store
    logic       store;   // coprocessor store
    logic       wide;    // two-word load or store
    logic       dop;     // coprocessor data operation
    logic       cond;    // condition is not "always"
    logic       cwr;     // conditional write of reg_idx
    logic [3:0] condv;
    logic [3:0] reg_idx;
  } dec_t;

  // history entry of one emitted word
  typedef struct packed {
    logic       wide;
    logic       cond;
    logic [3:0] condv;
    logic       dop;
    logic [3:0] reg_idx;
    logic       taken;
    logic       shadow;  // conditional write that followed a data op to the same register
  } hist_t;
endpackage

// File: rtl/copro_hazard_spacer_decode.sv
`timescale 1ns/1ps
module copro_hazard_spacer_decode
  import copro_hazard_spacer_pkg::*;
#(
  parameter int CP_LO = 4,
  parameter int CP_HI = 6
) (
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  logic [3:0] cp_num;
  logic       is_cp;

  assign cp_num = word[11:8];
  assign is_cp  = (int'(cp_num) >= CP_LO) && (int'(cp_num) <= CP_HI);

  always_comb begin
    dec         = '0;
    dec.cp      = is_cp;
    dec.ls      = is_cp && (word[27:25] == 3'b110);
    dec.store   = dec.ls && !word[20];
    dec.wide    = dec.ls && word[22];
    dec.dop     = is_cp && (word[27:24] == 4'b1110) && !word[4];
    dec.condv   = word[31:28];
    dec.cond    = word[31:28] != COND_ALWAYS;
    dec.reg_idx = word[15:12];
    dec.cwr     = is_cp && dec.cond && (dec.dop || (dec.ls && !dec.store));
  end
endmodule

// File: rtl/copro_hazard_spacer_rules.sv
`timescale 1ns/1ps
module copro_hazard_spacer_rules
  import copro_hazard_spacer_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int BR_SLOTS  = 2,
  parameter int WR_GAP    = 2,
  parameter int ST_GAP    = 3,
  parameter bit WIDE_TAIL = 1'b1
) (
  input  dec_t                   cand,
  input  logic                   cand_taken,
  input  hist_t [DEPTH-1:0]      hist,
  output logic                   need_nop,
  output hist_t                  entry
);
  localparam int SH_WIN = WR_GAP + 2;

  logic shadow_hit;
  logic tail_hit;
  logic pair_hit;
  logic window_hit;

  always_comb begin
    window_hit = 1'b0;
    shadow_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      // slots after a taken branch
      if (i < BR_SLOTS && hist[i].taken && cand.cp) window_hit = 1'b1;
      // conditional write too close to a data op on the same register
      if (i < WR_GAP && hist[i].dop && cand.cwr &&
          hist[i].reg_idx == cand.reg_idx) window_hit = 1'b1;
      // store too close to a shadowed conditional write
      if (i < ST_GAP && hist[i].shadow && cand.store &&
          hist[i].reg_idx == cand.reg_idx) window_hit = 1'b1;
      if (i < SH_WIN && hist[i].dop && cand.cwr &&
          hist[i].reg_idx == cand.reg_idx) shadow_hit = 1'b1;
    end
  end

  generate
    if (WIDE_TAIL) begin : g_tail
      assign tail_hit = cand.cp && hist[0].wide;
    end else begin : g_no_tail
      assign tail_hit = 1'b0;
    end
  endgenerate

  assign pair_hit = cand.ls && hist[0].wide && hist[0].cond &&
                    (hist[0].condv != cand.condv);

  assign need_nop = window_hit || tail_hit || pair_hit;

  always_comb begin
    entry = '0;
    if (!need_nop) begin
      entry.wide    = cand.wide;
      entry.cond    = cand.cond;
      entry.condv   = cand.condv;
      entry.dop     = cand.dop;
      entry.reg_idx = cand.reg_idx;
      entry.taken   = cand_taken;
      entry.shadow  = cand.cwr && shadow_hit;
    end
  end
endmodule

// File: rtl/copro_hazard_spacer_history.sv
`timescale 1ns/1ps
module copro_hazard_spacer_history
  import copro_hazard_spacer_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  hist_t             din,
  output hist_t [DEPTH-1:0] hist
);
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hist[g] <= '0;
        end else if (push) begin
          if (g == 0) hist[g] <= din;
          else        hist[g] <= hist[g-1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/copro_hazard_spacer.sv
`timescale 1ns/1ps
module copro_hazard_spacer
  import copro_hazard_spacer_pkg::*;
#(
  parameter bit          WIDE_TAIL = 1'b1,
  parameter logic [31:0] NOP_WORD  = 32'hE1A0_0000,
  parameter int          CP_LO     = 4,
  parameter int          CP_HI     = 6,
  parameter int          BR_SLOTS  = 2,
  parameter int          WR_GAP    = 2,
  parameter int          ST_GAP    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  input  logic        in_taken,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word
);
  localparam int SH_WIN = WR_GAP + 2;
  localparam int D_A    = (BR_SLOTS > ST_GAP) ? BR_SLOTS : ST_GAP;
  localparam int DEPTH  = (D_A > SH_WIN) ? D_A : SH_WIN;

  dec_t              cand;
  hist_t [DEPTH-1:0] hist;
  hist_t             entry;
  logic              need_nop;
  logic              adv;
  logic              push;
  logic              o_valid;
  logic [31:0]       o_word;

  copro_hazard_spacer_decode #(.CP_LO(CP_LO), .CP_HI(CP_HI)) u_dec (
    .word (in_word),
    .dec  (cand)
  );

  copro_hazard_spacer_rules #(
    .DEPTH(DEPTH), .BR_SLOTS(BR_SLOTS), .WR_GAP(WR_GAP),
    .ST_GAP(ST_GAP), .WIDE_TAIL(WIDE_TAIL)
  ) u_rules (
    .cand       (cand),
    .cand_taken (in_taken),
    .hist       (hist),
    .need_nop   (need_nop),
    .entry      (entry)
  );

  copro_hazard_spacer_history #(.DEPTH(DEPTH)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (entry),
    .hist  (hist)
  );

  assign adv      = !o_valid || out_ready;
  assign push     = adv && in_valid;
  assign in_ready = adv && !(in_valid && need_nop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_word  <= '0;
    end else if (adv) begin
      o_valid <= in_valid;
      if (in_valid) o_word <= need_nop ? NOP_WORD : in_word;
    end
  end

  assign out_valid = o_valid;
  assign out_word  = o_word;
endmodule

// File: rtl/copro_hazard_spacer_chk.sv
`timescale 1ns/1ps
module copro_hazard_spacer_chk #(
  parameter bit          WIDE_TAIL = 1'b1,
  parameter logic [31:0] NOP_WORD  = 32'hE1A0_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_word,
  input logic        in_taken,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word
);
  logic       fire;
  logic       o_cp;
  logic       o_ls;
  logic       o_wide;
  logic       ld_tk;
  logic       tk0, tk1;
  logic       prev_wide;
  logic       prev_cwide;
  logic [3:0] prev_cond;

  assign fire   = out_valid && out_ready;
  assign o_cp   = (out_word[11:8] >= 4'd4) && (out_word[11:8] <= 4'd6);
  assign o_ls   = o_cp && (out_word[27:25] == 3'b110);
  assign o_wide = o_ls && out_word[22];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_tk      <= 1'b0;
      tk0        <= 1'b0;
      tk1        <= 1'b0;
      prev_wide  <= 1'b0;
      prev_cwide <= 1'b0;
      prev_cond  <= 4'h0;
    end else begin
      if ((!out_valid || out_ready) && in_valid) ld_tk <= in_ready && in_taken;
      if (fire) begin
        tk0        <= ld_tk;
        tk1        <= tk0;
        prev_wide  <= o_wide;
        prev_cwide <= o_wide && (out_word[31:28] != 4'hE);
        prev_cond  <= out_word[31:28];
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_word == $past(in_word));

  a_r11_nop_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && (!out_valid || out_ready) |=> out_valid && out_word == NOP_WORD);

  a_r4_branch_slots: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (tk0 || tk1) |-> !o_cp);

  a_r5_wide_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE_TAIL != 1'b0) && fire && prev_wide |-> !o_cp);

  a_r6_pair_cond: assert property (@(posedge clk) disable iff (!rst_n)
    fire && prev_cwide && o_ls |-> out_word[31:28] == prev_cond);
endmodule

bind copro_hazard_spacer copro_hazard_spacer_chk #(
  .WIDE_TAIL(WIDE_TAIL), .NOP_WORD(NOP_WORD)
) u_chk (.*);

// File: tb/test_copro_hazard_spacer.sv
`timescale 1ns/1ps
module test_copro_hazard_spacer;
  localparam logic [31:0] NOP = 32'hE1A0_0000;
  localparam logic [31:0] ALU = 32'hE081_1002;
  localparam logic [31:0] BRA = 32'hEA00_0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic in_taken = 1'b0;
  logic sel = 1'b0;
  logic bp = 1'b0;
  logic rdy_a, rdy_b, ov_a, ov_b;
  logic ora = 1'b1, orb = 1'b1;
  logic [31:0] ow_a, ow_b;
  logic [31:0] qa[$];
  logic [31:0] qb[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  copro_hazard_spacer i_copro_hazard_spacer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && !sel), .in_ready(rdy_a),
    .in_word(in_word), .in_taken(in_taken), .out_valid(ov_a),
    .out_ready(ora), .out_word(ow_a));

  copro_hazard_spacer #(.WIDE_TAIL(1'b0)) i_copro_hazard_spacer_pair (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && sel), .in_ready(rdy_b),
    .in_word(in_word), .in_taken(in_taken), .out_valid(ov_b),
    .out_ready(orb), .out_word(ow_b));

  function automatic logic [31:0] ls(input logic [3:0] c, input bit load,
                                     input bit wide, input logic [3:0] cp, input logic [3:0] rd);
    return {c, 3'b110, 2'b00, wide, 1'b0, load, 4'h0, rd, cp, 8'h00};
  endfunction

  function automatic logic [31:0] dop(input logic [3:0] c, input logic [3:0] cp,
                                      input logic [3:0] rd);
    return {c, 4'b1110, 8'h00, rd, cp, 8'h00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic ex(input logic [31:0] w);
    if (sel) qb.push_back(w); else qa.push_back(w);
  endtask

  task automatic send(input logic [31:0] w, input bit tk, input string tag);
    @(negedge clk);
    in_word = w; in_taken = tk; in_valid = 1'b1;
    forever begin
      #1;
      if (sel ? rdy_b : rdy_a) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_taken = 1'b0;
    // R2: the accepted word is on the output one cycle later
    chk((sel ? ov_b : ov_a) && (sel ? ow_b : ow_a) == w, {"R2 ", tag}, sel ? ow_b : ow_a, w);
  endtask

  task automatic put(input logic [31:0] w, input string tag);
    ex(w); send(w, 1'b0, tag);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) put(ALU, "flush");
  endtask

  task automatic drain();
    int n = 0;
    while ((sel ? qb.size() : qa.size()) != 0 && n < 200) begin
      @(negedge clk); n++;
    end
    chk(n < 200, "R2 drain", 32'(n), 32'd0);
  endtask

  // scoreboard monitor for the default instance
  logic hold_a = 1'b0;
  logic [31:0] held_a = '0;
  always begin
    @(negedge clk);
    cyc++;
    ora = !bp || (cyc % 3 != 0);
    orb = !bp || (cyc % 3 != 1);
    #1;
    if (rst_n) begin
      if (hold_a) chk(ov_a && ow_a == held_a, "R2 hold", ow_a, held_a);
      if (ov_a && ora) begin
        if (qa.size() == 0) chk(1'b0, "R2 extra word", ow_a, 32'h0);
        else begin
          logic [31:0] e;
          e = qa.pop_front();
          chk(ow_a == e, "R4/R5/R8/R9/R11 stream", ow_a, e);
        end
      end
      hold_a = ov_a && !ora;
      held_a = ow_a;
    end
  end

  // scoreboard monitor for the pair-rule instance
  logic hold_b = 1'b0;
  logic [31:0] held_b = '0;
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (hold_b) chk(ov_b && ow_b == held_b, "R2 hold pair", ow_b, held_b);
      if (ov_b && orb) begin
        if (qb.size() == 0) chk(1'b0, "R2 extra word pair", ow_b, 32'h0);
        else begin
          logic [31:0] e;
          e = qb.pop_front();
          chk(ow_b == e, "R6/R7 stream", ow_b, e);
        end
      end
      hold_b = ov_b && !orb;
      held_b = ow_b;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    // R1: reset state
    chk(!ov_a && !ov_b, "R1 out_valid", {31'b0, ov_a}, 32'd0);
    chk(rdy_a && rdy_b, "R1 in_ready", {31'b0, rdy_a}, 32'd1);
    rst_n = 1'b1;
    chk(!ov_a, "R1 out_valid after release", {31'b0, ov_a}, 32'd0);

    // R2: plain pass-through order
    put(ALU, "order"); put(32'hE082_2003, "order"); put(dop(4'hE, 4'd4, 4'd1), "order");
    flush();

    // R4: taken branch slots
    ex(BRA); send(BRA, 1'b1, "R4 branch");
    ex(NOP); ex(NOP); put(dop(4'hE, 4'd5, 4'd2), "R4 two slots");
    ex(BRA); send(BRA, 1'b1, "R4 branch");
    put(ALU, "R4 slot filler"); ex(NOP); put(dop(4'hE, 4'd4, 4'd3), "R4 one slot");
    put(BRA, "R4 not taken"); put(dop(4'hE, 4'd6, 4'd4), "R4 not taken follower");
    flush();

    // R3: other coprocessor numbers are ignored
    ex(BRA); send(BRA, 1'b1, "R3 branch");
    put(ls(4'hE, 1'b1, 1'b1, 4'd7, 4'd1), "R3 cp7 after branch");
    put(ls(4'hE, 1'b1, 1'b1, 4'd3, 4'd1), "R3 cp3");
    put(dop(4'hE, 4'd4, 4'd9), "R3 cp4 after cp3 wide");
    flush();

    // R5: wide tail
    put(ls(4'hE, 1'b1, 1'b1, 4'd5, 4'd1), "R5 wide load");
    ex(NOP); put(dop(4'hE, 4'd4, 4'd2), "R5 cp after wide");
    put(ls(4'hE, 1'b0, 1'b1, 4'd5, 4'd1), "R5 wide store");
    put(ALU, "R5 non-cp after wide");
    put(ls(4'hE, 1'b1, 1'b0, 4'd5, 4'd5), "R5 narrow");
    put(ls(4'hE, 1'b1, 1'b0, 4'd5, 4'd6), "R5 narrow after narrow");
    flush();

    // R8 and R9: data op, conditional write, store
    put(dop(4'hE, 4'd4, 4'd3), "R8 data op");
    ex(NOP); ex(NOP); put(dop(4'h1, 4'd4, 4'd3), "R8 cond write");
    ex(NOP); ex(NOP); ex(NOP); put(ls(4'hE, 1'b0, 1'b0, 4'd4, 4'd3), "R9 store");
    flush();
    put(dop(4'hE, 4'd4, 4'd6), "R8 data op");
    put(ALU, "R8 spacer");
    ex(NOP); put(dop(4'h1, 4'd4, 4'd6), "R8 cond write one gap");
    put(ALU, "R9 spacer"); put(ALU, "R9 spacer");
    ex(NOP); put(ls(4'hE, 1'b0, 1'b0, 4'd4, 4'd6), "R9 store one gap");
    flush();
    put(dop(4'hE, 4'd4, 4'd7), "R8 other reg");
    put(dop(4'h1, 4'd4, 4'd8), "R8 different register no NOP");
    put(ls(4'hE, 1'b0, 1'b0, 4'd4, 4'd8), "R9 store no shadow");
    flush();

    // R10: idle gap does not separate
    put(ls(4'hE, 1'b0, 1'b1, 4'd6, 4'd2), "R10 wide store");
    repeat (3) @(negedge clk);
    ex(NOP); put(ls(4'hE, 1'b1, 1'b0, 4'd4, 4'd2), "R10 after idle");
    flush();

    // R2 with back-pressure; R11 NOP contents via stream
    bp = 1'b1;
    put(dop(4'hE, 4'd4, 4'd10), "R2 bp data op");
    ex(NOP); ex(NOP); put(dop(4'h2, 4'd4, 4'd10), "R11 bp cond write");
    put(ALU, "R2 bp alu"); put(ALU, "R2 bp alu");
    flush();
    drain();
    bp = 1'b0;

    // pair instance: R6 and R7
    sel = 1'b1;
    flush();
    put(ls(4'h3, 1'b0, 1'b1, 4'd5, 4'd1), "R6 cond wide");
    ex(NOP); put(ls(4'hE, 1'b1, 1'b0, 4'd4, 4'd2), "R6 different condition");
    put(ls(4'h3, 1'b0, 1'b1, 4'd5, 4'd1), "R7 cond wide");
    put(ls(4'h3, 1'b0, 1'b0, 4'd4, 4'd3), "R7 same condition");
    put(ls(4'hE, 1'b0, 1'b1, 4'd5, 4'd1), "R7 unconditional wide");
    put(ls(4'hE, 1'b1, 1'b1, 4'd5, 4'd4), "R7 after unconditional");
    put(ls(4'h3, 1'b0, 1'b1, 4'd5, 4'd1), "R7 cond wide");
    put(dop(4'hE, 4'd4, 4'd11), "R7 data op follower");
    flush();
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule